// File: doc/BRIEF.md
# SMBus Host Register and Block Buffer Front End

This block is the software-facing side of an SMBus master. A CPU reaches it through a small strobe-based register bus. Through that bus software loads a command byte, a target address and two data bytes, and selects byte or block mode. It then requests a transaction by writing a start bit. The block passes the request on to a downstream transaction engine through a start pulse. It keeps the staged values steady while the engine is working. When the engine reports done or error, or when software aborts with a kill bit, the block records the outcome in write-one-to-clear status bits and raises an interrupt.

Block payloads sit in a 32-byte store. The CPU never addresses this store directly. It goes through a single data register backed by a hidden index. The index returns to zero whenever the control register is read, and it steps forward on every access to the data register. The engine has its own pointer into the same store. That pointer restarts at entry 0 for every transaction. For block reads, the engine reports how many bytes arrived, and the block places that figure in data register 0.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0, the interrupt output is low, and the block index points at entry 0.
- R2: A control write with bit 6 (start) set is ignored unless the host is idle and status bits 1..3 are all clear. An ignored start produces no engine start pulse and does not set busy.
- R3: An accepted start sets status bit 0 (busy) and produces a one-cycle eng_start pulse in the cycle after the write. Busy clears on completion, on error, or on kill.
- R4: Every CPU read of the control register (address 1) resets the block index to 0. Every CPU read or write of the block data register (address 6) advances the index by one afterwards, and the index wraps from 31 to 0.
- R5: During a transaction eng_count equals data register 0 (address 4) when that value is 1..32, and equals 32 when it is 0 or above 32.
- R6: On completion of a block transaction (control bit 2 set) whose address register (address 3) has bit 0 set (read), data register 0 takes the engine's transferred-byte count.
- R7: Engine buffer accesses start at entry 0 after every accepted start, whatever the CPU index holds, and each engine read or write advances the engine pointer by one.
- R8: Status (address 0) bit 1 is set by eng_done, bit 2 by eng_err, and bit 3 by a control write with bit 1 (kill) while busy. A kill write also pulses eng_kill. Priority is kill, then error, then done.
- R9: Writing 1 to a status bit 1..3 clears it. Writing 0 leaves it unchanged.
- R10: irq is high exactly when control bit 0 (interrupt enable) is set and any status bit 1..3 is set.
- R11: While busy, CPU writes to the command, address, data 0, data 1 and block registers, and to control bit 2, are discarded.
- R12: eng_done and eng_err while idle, and a kill write while idle, change no status bit and produce no eng_kill pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from cpu_addr |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle transaction start pulse |
| eng_kill | output | 1 | One-cycle abort pulse |
| eng_cmd | output | 8 | Staged command byte |
| eng_addr | output | 8 | Staged target address, bit 0 = read |
| eng_dat0 | output | 8 | Staged data register 0 |
| eng_dat1 | output | 8 | Staged data register 1 |
| eng_blk | output | 1 | Block mode selected |
| eng_count | output | 6 | Clamped block byte count, 1..32 |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error pulse |
| eng_xfer_cnt | input | 6 | Bytes received, valid with eng_done |
| eng_buf_rd | input | 1 | Engine reads the buffer entry at its pointer |
| eng_buf_wr | input | 1 | Engine writes the buffer entry at its pointer |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Buffer entry at the engine pointer |

## Verification
Two situations are hard to reach from the ports. The first is an engine access that must land on entry 0 while the CPU index sits somewhere else. The bench leaves the CPU index at a different position before each start and then walks the engine through the store. The second is a start request that arrives while a status bit is still pending. The bench deliberately leaves a done or error bit uncleared, writes start again, and confirms that no pulse appears. Count clamping is swept across every data register 0 value from 0 to 40.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  typedef enum logic [2:0] {
    RA_STAT = 3'd0,
    RA_CTRL = 3'd1,
    RA_CMD  = 3'd2,
    RA_ADDR = 3'd3,
    RA_DAT0 = 3'd4,
    RA_DAT1 = 3'd5,
    RA_BLK  = 3'd6
  } reg_addr_e;

  localparam int CB_IE    = 0;
  localparam int CB_KILL  = 1;
  localparam int CB_BLK   = 2;
  localparam int CB_START = 6;

  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;
  localparam int SB_ERR  = 2;
  localparam int SB_KILL = 3;

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_idx_clr,
  input  logic          cpu_acc,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          eng_ptr_clr,
  input  logic          eng_acc,
  input  logic          eng_we,
  input  logic [DW-1:0] eng_wdata,
  output logic [DW-1:0] eng_rdata
);
  localparam int PTR_W = $clog2(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] idx_q, eptr_q;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic [DW-1:0]    wr_data;

  always_comb begin
    wr_en   = cpu_we | eng_we;
    wr_ptr  = cpu_we ? idx_q : eptr_q;
    wr_data = cpu_we ? cpu_wdata : eng_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           idx_q <= '0;
    else if (cpu_idx_clr) idx_q <= '0;
    else if (cpu_acc)     idx_q <= ptr_step(idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           eptr_q <= '0;
    else if (eng_ptr_clr) eptr_q <= '0;
    else if (eng_acc)     eptr_q <= ptr_step(eptr_q);
  end

  assign cpu_rdata = mem[idx_q];
  assign eng_rdata = mem[eptr_q];

  p_idx_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_acc && !cpu_idx_clr && idx_q == PTR_W'(DEPTH - 1)) |=> idx_q == '0);
  p_idx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_idx_clr |=> idx_q == '0);
  p_eptr_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ptr_clr |=> eptr_q == '0);
  p_single_writer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && eng_we));
endmodule

// File: rtl/smb_host_ctl.sv
module smb_host_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       kill_req,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       clr_en,
  input  logic [3:0] clr_mask,
  output logic [3:0] stat,
  output logic       start_acc,
  output logic       done_evt,
  output logic       eng_start,
  output logic       eng_kill
);
  logic busy_q, done_q, err_q, kill_q, start_q, killp_q;
  logic pending, kill_evt, err_evt, finish;

  always_comb begin
    pending   = done_q | err_q | kill_q;
    start_acc = start_req & ~busy_q & ~pending;
    kill_evt  = kill_req & busy_q;
    err_evt   = busy_q & eng_err & ~kill_req;
    done_evt  = busy_q & eng_done & ~eng_err & ~kill_req;
    finish    = kill_evt | err_evt | done_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      kill_q  <= 1'b0;
      start_q <= 1'b0;
      killp_q <= 1'b0;
    end else begin
      if (start_acc)   busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      done_q  <= (done_q & ~(clr_en & clr_mask[1])) | done_evt;
      err_q   <= (err_q  & ~(clr_en & clr_mask[2])) | err_evt;
      kill_q  <= (kill_q & ~(clr_en & clr_mask[3])) | kill_evt;
      start_q <= start_acc;
      killp_q <= kill_evt;
    end
  end

  assign stat      = {kill_q, err_q, done_q, busy_q};
  assign eng_start = start_q;
  assign eng_kill  = killp_q;

  p_start_needs_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(!pending));
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy_q ##1 !eng_start);
  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy_q && done_q));
  p_kill_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_kill |-> (kill_q && !busy_q));
  p_idle_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_acc && !clr_en) |=> $stable({kill_q, err_q, done_q}));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_rd,
  input  logic                       cpu_wr,
  input  logic [2:0]                 cpu_addr,
  input  logic [DW-1:0]              cpu_wdata,
  output logic [DW-1:0]              cpu_rdata,
  output logic                       irq,
  output logic                       eng_start,
  output logic                       eng_kill,
  output logic [DW-1:0]              eng_cmd,
  output logic [DW-1:0]              eng_addr,
  output logic [DW-1:0]              eng_dat0,
  output logic [DW-1:0]              eng_dat1,
  output logic                       eng_blk,
  output logic [$clog2(DEPTH):0]     eng_count,
  input  logic                       eng_done,
  input  logic                       eng_err,
  input  logic [$clog2(DEPTH):0]     eng_xfer_cnt,
  input  logic                       eng_buf_rd,
  input  logic                       eng_buf_wr,
  input  logic [DW-1:0]              eng_buf_wdata,
  output logic [DW-1:0]              eng_buf_rdata
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  function automatic logic [CNT_W-1:0] clamp_count(input logic [DW-1:0] v);
    if (v == '0 || int'(v) > DEPTH) return CNT_W'(DEPTH);
    return CNT_W'(v);
  endfunction

  logic [DW-1:0] cmd_q, addr_q, dat0_q, dat1_q;
  logic          ie_q, blk_q;
  logic [3:0]    stat;
  logic          busy;
  logic          start_acc, done_evt;
  logic          hit_ctrl, hit_blk, hit_stat, wr_ok;
  logic          start_req, kill_req;
  logic [DW-1:0] buf_cpu_rdata;

  always_comb begin
    hit_ctrl  = (cpu_addr == RA_CTRL);
    hit_blk   = (cpu_addr == RA_BLK);
    hit_stat  = (cpu_addr == RA_STAT);
    wr_ok     = cpu_wr & ~busy;
    start_req = cpu_wr & hit_ctrl & cpu_wdata[CB_START];
    kill_req  = cpu_wr & hit_ctrl & cpu_wdata[CB_KILL];
  end

  smb_host_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .kill_req  (kill_req),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .clr_en    (cpu_wr & hit_stat),
    .clr_mask  (cpu_wdata[3:0]),
    .stat      (stat),
    .start_acc (start_acc),
    .done_evt  (done_evt),
    .eng_start (eng_start),
    .eng_kill  (eng_kill)
  );
  assign busy = stat[SB_BUSY];

  smb_blk_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_idx_clr (cpu_rd & hit_ctrl),
    .cpu_acc     ((cpu_rd | cpu_wr) & hit_blk),
    .cpu_we      (wr_ok & hit_blk),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (buf_cpu_rdata),
    .eng_ptr_clr (start_acc),
    .eng_acc     (busy & (eng_buf_rd | eng_buf_wr)),
    .eng_we      (busy & eng_buf_wr),
    .eng_wdata   (eng_buf_wdata),
    .eng_rdata   (eng_buf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      dat0_q <= '0;
      dat1_q <= '0;
      ie_q   <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      if (cpu_wr && hit_ctrl) ie_q <= cpu_wdata[CB_IE];
      if (wr_ok && hit_ctrl) blk_q <= cpu_wdata[CB_BLK];
      if (wr_ok && cpu_addr == RA_CMD)  cmd_q  <= cpu_wdata;
      if (wr_ok && cpu_addr == RA_ADDR) addr_q <= cpu_wdata;
      if (wr_ok && cpu_addr == RA_DAT1) dat1_q <= cpu_wdata;
      if (done_evt && blk_q && addr_q[0]) dat0_q <= DW'(eng_xfer_cnt);
      else if (wr_ok && cpu_addr == RA_DAT0) dat0_q <= cpu_wdata;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      RA_STAT: cpu_rdata = DW'(stat);
      RA_CTRL: begin
        cpu_rdata[CB_IE]  = ie_q;
        cpu_rdata[CB_BLK] = blk_q;
      end
      RA_CMD:  cpu_rdata = cmd_q;
      RA_ADDR: cpu_rdata = addr_q;
      RA_DAT0: cpu_rdata = dat0_q;
      RA_DAT1: cpu_rdata = dat1_q;
      RA_BLK:  cpu_rdata = buf_cpu_rdata;
      default: cpu_rdata = '0;
    endcase
  end

  assign irq       = ie_q & (|stat[SB_KILL:SB_DONE]);
  assign eng_cmd   = cmd_q;
  assign eng_addr  = addr_q;
  assign eng_dat0  = dat0_q;
  assign eng_dat1  = dat1_q;
  assign eng_blk   = blk_q;
  assign eng_count = clamp_count(dat0_q);

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_count >= CNT_W'(1) && eng_count <= CNT_W'(DEPTH)));
  p_hold_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cmd_q) && $stable(addr_q) && $stable(dat1_q) && $stable(blk_q)));
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done_evt) || $past(eng_err) || $past(kill_req) || $past(cpu_wr)));
endmodule

// File: tb/smb_host_regs_bench.sv
module smb_host_regs_bench;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 32;

  logic clk = 0, rst_n = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [2:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic irq, eng_start, eng_kill, eng_blk;
  logic [7:0] eng_cmd, eng_addr, eng_dat0, eng_dat1;
  logic [5:0] eng_count, eng_xfer_cnt = 0;
  logic eng_done = 0, eng_err = 0, eng_buf_rd = 0, eng_buf_wr = 0;
  logic [7:0] eng_buf_wdata = 0, eng_buf_rdata;

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rv;

  always #(PERIOD/2) clk = ~clk;

  smb_host_regs u_smb_host_regs (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq), .eng_start(eng_start),
    .eng_kill(eng_kill), .eng_cmd(eng_cmd), .eng_addr(eng_addr), .eng_dat0(eng_dat0),
    .eng_dat1(eng_dat1), .eng_blk(eng_blk), .eng_count(eng_count), .eng_done(eng_done),
    .eng_err(eng_err), .eng_xfer_cnt(eng_xfer_cnt), .eng_buf_rd(eng_buf_rd),
    .eng_buf_wr(eng_buf_wr), .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = a; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic eng_pulse(input logic dn, input logic er, input logic [5:0] cnt);
    @(negedge clk); eng_done = dn; eng_err = er; eng_xfer_cnt = cnt;
    @(negedge clk); eng_done = 0; eng_err = 0;
  endtask

  task automatic eng_read(output logic [7:0] d);
    @(negedge clk); eng_buf_rd = 1; #1 d = eng_buf_rdata;
    @(negedge clk); eng_buf_rd = 0;
  endtask

  task automatic eng_write(input logic [7:0] d);
    @(negedge clk); eng_buf_wr = 1; eng_buf_wdata = d;
    @(negedge clk); eng_buf_wr = 0;
  endtask

  function automatic int exp_count(input int d);
    return (d == 0 || d > DEPTH) ? DEPTH : d;
  endfunction

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", irq, 0);
    for (int a = 0; a < 7; a++) begin rd(3'(a), rv); check("R1 reg", rv, 0); end

    // R4 index sweep with wrap
    rd(1, rv);
    for (int i = 0; i < 40; i++) begin
      wr(6, 8'((i * 37 + 11) & 255));
      model[i % DEPTH] = 8'((i * 37 + 11) & 255);
    end
    rd(1, rv);
    for (int i = 0; i < 33; i++) begin rd(6, rv); check("R4 blk read", rv, model[i % DEPTH]); end
    rd(1, rv);
    rd(6, rv); check("R4 ctrl read resets index", rv, model[0]);

    // R5 / R3 / R7 count sweep, block write
    wr(3, 8'h20);
    for (int d = 0; d <= 40; d++) begin
      wr(4, 8'(d));
      for (int s = 0; s < d % 5; s++) rd(6, rv);
      wr(1, 8'h45);
      check("R3 start pulse", eng_start, 1);
      check("R5 count", eng_count, exp_count(d));
      @(negedge clk); check("R3 pulse one cycle", eng_start, 0);
      rd(0, rv); check("R3 busy", rv, 1);
      if (d % 8 == 0) begin
        for (int k = 0; k < exp_count(d); k++) begin
          eng_read(rv); check("R7 engine read from 0", rv, model[k]);
        end
      end
      eng_pulse(1, 0, 0);
      check("R10 irq on done", irq, 1);
      rd(0, rv); check("R8 done status", rv, 2);
      rd(4, rv); check("R6 write dir keeps dat0", rv, d);
      wr(0, 8'h02);
      rd(0, rv); check("R9 w1c", rv, 0);
      check("R10 irq cleared", irq, 0);
    end

    // R2 start gated by pending status
    wr(4, 8'd3); wr(1, 8'h45); eng_pulse(1, 0, 0);
    wr(1, 8'h45); check("R2 no pulse done pending", eng_start, 0);
    rd(0, rv); check("R2 not busy", rv, 2);
    wr(0, 8'h00); rd(0, rv); check("R9 write 0 no effect", rv, 2);
    wr(0, 8'h02);
    wr(1, 8'h45); eng_pulse(0, 1, 0);
    rd(0, rv); check("R8 err status", rv, 4);
    wr(1, 8'h45); check("R2 no pulse err pending", eng_start, 0);
    wr(0, 8'h04);

    // R11 writes discarded while busy
    wr(2, 8'h5A); wr(5, 8'h66); wr(4, 8'd2);
    rd(1, rv);
    wr(1, 8'h45);
    wr(2, 8'hAA); wr(3, 8'h77); wr(4, 8'h99); wr(5, 8'h11); wr(6, 8'hEE);
    wr(1, 8'h01);
    rd(2, rv); check("R11 cmd held", rv, 8'h5A);
    rd(3, rv); check("R11 addr held", rv, 8'h20);
    rd(4, rv); check("R11 dat0 held", rv, 2);
    rd(5, rv); check("R11 dat1 held", rv, 8'h66);
    rd(1, rv); check("R11 blk mode held", rv, 8'h05);
    rd(6, rv); check("R11 blk data held", rv, model[0]);
    eng_pulse(1, 0, 0); wr(0, 8'h0E);

    // R12 idle events ignored
    eng_pulse(1, 0, 0); eng_pulse(0, 1, 0);
    wr(1, 8'h07); check("R12 no kill pulse idle", eng_kill, 0);
    rd(0, rv); check("R12 idle status", rv, 0);

    // R6 block read
    wr(3, 8'h21);
    for (int n = 1; n <= DEPTH; n += 7) begin
      rd(1, rv); rd(6, rv); rd(6, rv);
      wr(1, 8'h45);
      for (int k = 0; k < n; k++) begin
        eng_write(8'((n * 13 + k * 5) & 255)); model[k] = 8'((n * 13 + k * 5) & 255);
      end
      eng_pulse(1, 0, 6'(n));
      rd(4, rv); check("R6 dat0 count", rv, n);
      rd(1, rv);
      for (int k = 0; k < n; k++) begin rd(6, rv); check("R6 block data", rv, model[k]); end
      wr(0, 8'h02);
    end

    // R8 kill and priority
    wr(1, 8'h45);
    wr(1, 8'h07); check("R8 kill pulse", eng_kill, 1);
    rd(0, rv); check("R8 kill status", rv, 8);
    wr(0, 8'h08);
    wr(1, 8'h45); eng_pulse(1, 1, 0);
    rd(0, rv); check("R8 err beats done", rv, 4);
    wr(0, 8'h04);

    // R10 interrupt enable off
    wr(1, 8'h44); eng_pulse(1, 0, 6'd1);
    check("R10 irq masked", irq, 0);
    rd(0, rv); check("R10 status still set", rv, 2);
    wr(1, 8'h05); check("R10 irq unmasked", irq, 1);
    wr(0, 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule